// File: doc/BRIEF.md
# PCM Highway Timeslot Port

This block is the slave end of a time-division PCM serial highway. A bit clock and a frame-sync pulse come from outside. Once per frame the block sends one sample out on a serial transmit line and takes one sample in from a serial receive line. Each direction has its own slot, set by a start count. The start count is the number of bit-clock cycles between the frame-sync rising edge and the first bit. Several devices can therefore share one highway, each in a different slot.

Configuration inputs select 8-bit samples or 16-bit linear samples, and normal or double-clocked bit timing. They also select when the transmit driver lets go of the line. It can release half a cycle early, in the falling half of the last cycle, or at the next rising edge. Early release lets a neighbour drive the next slot without contention. The parallel side takes a transmit sample, which is captured at the frame-sync edge. It returns each received sample with a one-cycle valid strobe. The pad driver is outside the block, which provides the data bit and an output enable.

Top module: `pcm_hwy_port`

## Requirements
- R1: Frame timing starts only at a rising edge of `fsync` seen at a rising `pclk` edge. Position 0 is the cycle that begins at that edge. The high time of `fsync` has no effect, so a one-cycle pulse and a pulse lasting most of the frame give the same frame.
- R2: With transmit start count T, the MSB is launched at the rising edge that begins position T. A count of 0 puts the MSB in position 0. The following bits come out MSB first, one per bit period.
- R3: With receive start count S, `drx` is sampled on the falling edge of each bit's cycle, MSB first, starting at position S.
- R4: When `cfg_wide`=0, a sample is 8 bits. `tx_sample[7:0]` is sent and `tx_sample[15:8]` is ignored. The received byte appears in `rx_sample[7:0]`, with `rx_sample[15:8]` equal to 0.
- R5: When `cfg_wide`=1, a sample is 16 bits, filling two 8-bit slot widths.
- R6: When `cfg_dbl`=1, each bit lasts two `pclk` cycles. Receive sampling uses the falling edge of the first of the two cycles.
- R7: `dtx_oe` is high only during the transmit window of 8, 16 or 32 cycles. `dtx` is 0 whenever `dtx_oe` is low.
- R8: When `cfg_tri_early`=1, `dtx_oe` falls at the falling `pclk` edge inside the last cycle of the window. When `cfg_tri_early`=0, it falls at the rising edge that ends that cycle.
- R9: The transmit sample is captured from `tx_sample` at the frame-sync edge. Changes to `tx_sample` later in the same frame do not affect the bits sent.
- R10: `rx_valid` is high for exactly one cycle. That cycle is the one after the cycle in which the LSB was sampled. `rx_sample` takes its new value in that cycle and holds it at all other times.
- R11: No transfer happens in a direction whose start count lies beyond the frame length. The position count saturates, so there is never a second transfer in one frame, however long the frame is. There is also no transfer before the first frame-sync edge after reset.
- R12: While `rst_n` is low and after it is released, `dtx`, `dtx_oe`, `rx_valid` and `rx_sample` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Highway bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fsync | input | 1 | Frame sync, rising edge marks position 0 |
| drx | input | 1 | Serial receive data |
| cfg_tx_start | input | 10 | Transmit start count in `pclk` cycles |
| cfg_rx_start | input | 10 | Receive start count in `pclk` cycles |
| cfg_wide | input | 1 | 1 = 16-bit linear samples, 0 = 8-bit samples |
| cfg_dbl | input | 1 | 1 = each bit spans two `pclk` cycles |
| cfg_tri_early | input | 1 | 1 = release driver in the falling half of the last cycle |
| tx_sample | input | 16 | Parallel transmit sample |
| dtx | output | 1 | Serial transmit data |
| dtx_oe | output | 1 | Transmit driver enable |
| rx_sample | output | 16 | Last received sample |
| rx_valid | output | 1 | One-cycle strobe for a new received sample |

## Verification
The bound checker watches properties on every cycle. A zero transmit start count enables the driver in the cycle after the frame-sync edge, `rx_valid` never lasts more than one cycle, and `rx_sample` does not change outside the strobe. It also checks that no enable run is longer than the widest window and that there is at most one transmit burst between frame-sync edges. Only the bench scenarios can show the exact bit values and bit positions for each format and bit timing. They also show the half-cycle release edge, that a late change to the transmit sample has no effect, and that no second transfer appears in a frame longer than the position counter's range.

// File: rtl/pcm_hwy_pkg.sv
package pcm_hwy_pkg;

    // Transfer fields that the transmit lane needs
    typedef struct packed {
        logic wide;
        logic dbl;
        logic tri_early;
    } pcm_fmt_t;

    // Number of pclk cycles a sample occupies on the highway
    function automatic int unsigned win_cycles(input logic wide, input logic dbl,
                                               input int unsigned wide_bits,
                                               input int unsigned narrow_bits);
        int unsigned b;
        b = wide ? wide_bits : narrow_bits;
        return dbl ? (2 * b) : b;
    endfunction

endpackage

// File: rtl/pcm_frame_timer.sv
module pcm_frame_timer #(
    parameter int CNT_W = 11
) (
    input  logic             pclk,
    input  logic             rst_n,
    input  logic             fsync,
    output logic             frame_start,
    output logic [CNT_W-1:0] pos
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic             fs_prev;
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t st_q, st_d;

    always_comb begin
        st_d         = st_q;
        frame_start  = fsync & ~st_q.fs_prev;
        pos          = frame_start ? '0 : st_q.cnt;
        st_d.fs_prev = fsync;
        st_d.cnt     = (pos == CNT_MAX) ? pos : pos + 1'b1;
    end

    always_ff @(posedge pclk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{fs_prev: 1'b0, cnt: CNT_MAX};
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/pcm_tx_lane.sv
module pcm_tx_lane
    import pcm_hwy_pkg::*;
#(
    parameter int CNT_W    = 11,
    parameter int START_W  = 10,
    parameter int SAMPLE_W = 16,
    parameter int NARROW_W = 8
) (
    input  logic                pclk,
    input  logic                rst_n,
    input  logic                frame_start,
    input  logic [CNT_W-1:0]    pos,
    input  logic [START_W-1:0]  start,
    input  pcm_fmt_t            fmt,
    input  logic [SAMPLE_W-1:0] tx_sample,
    output logic                dtx,
    output logic                dtx_oe
);
    localparam int IDX_W = $clog2(SAMPLE_W);

    typedef struct packed {
        logic [SAMPLE_W-1:0] hold;
        logic                oe;
        logic                dat;
        logic                last;
    } tx_t;

    tx_t st_q, st_d;
    logic kill_q;

    logic [CNT_W-1:0]    len;
    logic [CNT_W-1:0]    offs;
    logic [CNT_W-1:0]    step;
    logic [IDX_W-1:0]    idx;
    logic [SAMPLE_W-1:0] src;
    logic                in_win;

    always_comb begin
        st_d   = st_q;
        len    = CNT_W'(win_cycles(fmt.wide, fmt.dbl, SAMPLE_W, NARROW_W));
        offs   = pos - CNT_W'(start);
        in_win = (pos >= CNT_W'(start)) && (offs < len);
        step   = fmt.dbl ? (offs >> 1) : offs;
        idx    = IDX_W'(fmt.wide ? SAMPLE_W - 1 : NARROW_W - 1) - IDX_W'(step);
        src    = frame_start ? tx_sample : st_q.hold;

        st_d.hold = src;
        st_d.oe   = in_win;
        st_d.dat  = in_win & src[idx];
        st_d.last = in_win && (offs == len - 1'b1);
    end

    always_ff @(posedge pclk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // Half-cycle release marker, set in the falling half of the last cycle
    always_ff @(negedge pclk or negedge rst_n) begin
        if (!rst_n) begin
            kill_q <= 1'b0;
        end else begin
            kill_q <= st_q.last;
        end
    end

    assign dtx_oe = st_q.oe & ~(fmt.tri_early & kill_q & st_q.last);
    assign dtx    = st_q.dat & dtx_oe;
endmodule

// File: rtl/pcm_rx_lane.sv
module pcm_rx_lane
    import pcm_hwy_pkg::*;
#(
    parameter int CNT_W    = 11,
    parameter int START_W  = 10,
    parameter int SAMPLE_W = 16,
    parameter int NARROW_W = 8
) (
    input  logic                pclk,
    input  logic                rst_n,
    input  logic [CNT_W-1:0]    pos,
    input  logic [START_W-1:0]  start,
    input  logic                wide,
    input  logic                dbl,
    input  logic                drx,
    output logic [SAMPLE_W-1:0] rx_sample,
    output logic                rx_valid
);
    typedef struct packed {
        logic                samp;
        logic                last;
        logic                valid;
        logic [SAMPLE_W-1:0] data;
    } rx_t;

    rx_t st_q, st_d;
    logic [SAMPLE_W-1:0] shift_q;

    logic [CNT_W-1:0] len;
    logic [CNT_W-1:0] offs;
    logic             in_win;

    always_comb begin
        st_d   = st_q;
        len    = CNT_W'(win_cycles(wide, dbl, SAMPLE_W, NARROW_W));
        offs   = pos - CNT_W'(start);
        in_win = (pos >= CNT_W'(start)) && (offs < len);

        st_d.samp  = in_win & (~dbl | ~offs[0]);
        st_d.last  = in_win && (offs == len - CNT_W'(1) - CNT_W'(dbl));
        st_d.valid = st_q.last;
        if (st_q.last) begin
            st_d.data = wide ? shift_q
                             : {{(SAMPLE_W-NARROW_W){1'b0}}, shift_q[NARROW_W-1:0]};
        end
    end

    always_ff @(posedge pclk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(negedge pclk or negedge rst_n) begin
        if (!rst_n) begin
            shift_q <= '0;
        end else if (st_q.samp) begin
            shift_q <= {shift_q[SAMPLE_W-2:0], drx};
        end
    end

    assign rx_sample = st_q.data;
    assign rx_valid  = st_q.valid;
endmodule

// File: rtl/pcm_hwy_port.sv
module pcm_hwy_port
    import pcm_hwy_pkg::*;
#(
    parameter int START_W  = 10,
    parameter int SAMPLE_W = 16,
    parameter int NARROW_W = 8
) (
    input  logic                pclk,
    input  logic                rst_n,
    input  logic                fsync,
    input  logic                drx,
    input  logic [START_W-1:0]  cfg_tx_start,
    input  logic [START_W-1:0]  cfg_rx_start,
    input  logic                cfg_wide,
    input  logic                cfg_dbl,
    input  logic                cfg_tri_early,
    input  logic [SAMPLE_W-1:0] tx_sample,
    output logic                dtx,
    output logic                dtx_oe,
    output logic [SAMPLE_W-1:0] rx_sample,
    output logic                rx_valid
);
    // Wide enough to pass the latest window end, so saturation never hits a slot
    localparam int CNT_W = $clog2((1 << START_W) + 2 * SAMPLE_W + 1);

    logic             frame_start;
    logic [CNT_W-1:0] pos;
    pcm_fmt_t         fmt;

    assign fmt = '{wide: cfg_wide, dbl: cfg_dbl, tri_early: cfg_tri_early};

    pcm_frame_timer #(.CNT_W(CNT_W)) u_timer (
        .pclk        (pclk),
        .rst_n       (rst_n),
        .fsync       (fsync),
        .frame_start (frame_start),
        .pos         (pos)
    );

    pcm_tx_lane #(
        .CNT_W(CNT_W), .START_W(START_W), .SAMPLE_W(SAMPLE_W), .NARROW_W(NARROW_W)
    ) u_tx (
        .pclk        (pclk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .pos         (pos),
        .start       (cfg_tx_start),
        .fmt         (fmt),
        .tx_sample   (tx_sample),
        .dtx         (dtx),
        .dtx_oe      (dtx_oe)
    );

    pcm_rx_lane #(
        .CNT_W(CNT_W), .START_W(START_W), .SAMPLE_W(SAMPLE_W), .NARROW_W(NARROW_W)
    ) u_rx (
        .pclk      (pclk),
        .rst_n     (rst_n),
        .pos       (pos),
        .start     (cfg_rx_start),
        .wide      (cfg_wide),
        .dbl       (cfg_dbl),
        .drx       (drx),
        .rx_sample (rx_sample),
        .rx_valid  (rx_valid)
    );
endmodule

// File: rtl/pcm_hwy_checker.sv
module pcm_hwy_checker #(
    parameter int START_W  = 10,
    parameter int SAMPLE_W = 16
) (
    input logic                pclk,
    input logic                rst_n,
    input logic                fsync,
    input logic [START_W-1:0]  tx_start,
    input logic                dtx_oe,
    input logic                rx_valid,
    input logic [SAMPLE_W-1:0] rx_sample
);
    localparam int RUN_MAX = 2 * SAMPLE_W;
    localparam int RUN_W   = $clog2(RUN_MAX) + 2;

    logic             fs_prev_q;
    logic             oe_prev_q;
    logic [RUN_W-1:0] run_q;
    logic [1:0]       bursts_q;

    always_ff @(posedge pclk or negedge rst_n) begin
        if (!rst_n) begin
            fs_prev_q <= 1'b0;
            oe_prev_q <= 1'b0;
            run_q     <= '0;
            bursts_q  <= '0;
        end else begin
            fs_prev_q <= fsync;
            oe_prev_q <= dtx_oe;
            if (!dtx_oe) begin
                run_q <= '0;
            end else if (run_q != '1) begin
                run_q <= run_q + 1'b1;
            end
            if (fsync && !fs_prev_q) begin
                bursts_q <= '0;
            end else if (dtx_oe && !oe_prev_q && bursts_q != 2'b11) begin
                bursts_q <= bursts_q + 1'b1;
            end
        end
    end

    AST_START_ZERO_DRIVES: assert property (@(posedge pclk) disable iff (!rst_n)
        (fsync && !fs_prev_q && tx_start == '0) |=> dtx_oe); // R2

    AST_VALID_ONE_CYCLE: assert property (@(posedge pclk) disable iff (!rst_n)
        rx_valid |=> !rx_valid); // R10

    AST_SAMPLE_HELD: assert property (@(posedge pclk) disable iff (!rst_n)
        !rx_valid |-> $stable(rx_sample)); // R10

    AST_OE_RUN_BOUND: assert property (@(posedge pclk) disable iff (!rst_n)
        run_q <= RUN_W'(RUN_MAX)); // R7

    AST_ONE_BURST_PER_FRAME: assert property (@(posedge pclk) disable iff (!rst_n)
        bursts_q <= 2'd1); // R11
endmodule

bind pcm_hwy_port pcm_hwy_checker #(.START_W(START_W), .SAMPLE_W(SAMPLE_W)) u_chk (
    .pclk      (pclk),
    .rst_n     (rst_n),
    .fsync     (fsync),
    .tx_start  (cfg_tx_start),
    .dtx_oe    (dtx_oe),
    .rx_valid  (rx_valid),
    .rx_sample (rx_sample)
);

// File: tb/sim_pcm_hwy_port.sv
`timescale 1ns/100ps
module sim_pcm_hwy_port;
    logic        pclk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fsync = 1'b0;
    logic        drx = 1'b0;
    logic [9:0]  cfg_tx_start = '0;
    logic [9:0]  cfg_rx_start = '0;
    logic        cfg_wide = 1'b0;
    logic        cfg_dbl = 1'b0;
    logic        cfg_tri_early = 1'b0;
    logic [15:0] tx_sample = '0;
    logic        dtx;
    logic        dtx_oe;
    logic [15:0] rx_sample;
    logic        rx_valid;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #2 pclk = ~pclk;  // 250 MHz

    pcm_hwy_port u0 (
        .pclk(pclk), .rst_n(rst_n), .fsync(fsync), .drx(drx),
        .cfg_tx_start(cfg_tx_start), .cfg_rx_start(cfg_rx_start),
        .cfg_wide(cfg_wide), .cfg_dbl(cfg_dbl), .cfg_tri_early(cfg_tri_early),
        .tx_sample(tx_sample), .dtx(dtx), .dtx_oe(dtx_oe),
        .rx_sample(rx_sample), .rx_valid(rx_valid)
    );

    task automatic chk(input bit ok, input string req, input string tag,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h at %0t", req, tag, act, exp, $time);
        end
    endtask

    // Reference model: one frame, positions counted from the fsync rise the bench makes
    task automatic run_frame(input int len, input int fsw, input int txs, input int rxs,
                             input bit wide, input bit dbl, input bit tri_e,
                             input logic [15:0] tv, input logic [15:0] rv,
                             input string tag);
        int n;
        int span;
        int s_lsb;
        logic [15:0] mask;
        n     = wide ? 16 : 8;
        span  = dbl ? 2 * n : n;
        s_lsb = rxs + span - 1 - (dbl ? 1 : 0);
        mask  = wide ? 16'hFFFF : 16'h00FF;
        @(posedge pclk); #1;
        cfg_tx_start = 10'(txs); cfg_rx_start = 10'(rxs);
        cfg_wide = wide; cfg_dbl = dbl; cfg_tri_early = tri_e;
        tx_sample = tv; fsync = 1'b1; drx = 1'b0;
        for (int c = 0; c < len; c++) begin
            bit exp_oe;
            bit exp_d;
            bit exp_lo;
            bit exp_v;
            @(posedge pclk); #1;
            if (c == 0) tx_sample = ~tv;  // R9: must not reach the line
            fsync = (c + 1 < fsw);
            if (c >= rxs && c < rxs + span)
                drx = rv[n - 1 - (dbl ? (c - rxs) / 2 : (c - rxs))];
            else
                drx = (c % 3 == 0);
            #0.5;
            exp_oe = (c >= txs) && (c < txs + span);
            exp_d  = exp_oe ? tv[n - 1 - (dbl ? (c - txs) / 2 : (c - txs))] : 1'b0;
            exp_v  = (c == s_lsb + 1);
            chk(dtx_oe == exp_oe, "R7", tag, int'(dtx_oe), int'(exp_oe));
            chk(dtx == exp_d, "R2/R9", tag, int'(dtx), int'(exp_d));
            chk(rx_valid == exp_v, "R10", tag, int'(rx_valid), int'(exp_v));
            if (exp_v) chk(rx_sample == (rv & mask), "R3", tag, int'(rx_sample), int'(rv & mask));
            #1.5;
            exp_lo = exp_oe && !(tri_e && c == txs + span - 1);
            chk(dtx_oe == exp_lo, "R8", tag, int'(dtx_oe), int'(exp_lo));
        end
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=hung expected=finished");
            report();
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge pclk);
        #1;
        chk(dtx_oe == 1'b0 && dtx == 1'b0, "R12", "reset tx", int'(dtx_oe), 0);
        chk(rx_valid == 1'b0 && rx_sample == 16'h0, "R12", "reset rx", int'(rx_sample), 0);
        rst_n = 1'b1;
        // no fsync yet: start 0 must not transfer
        for (int i = 0; i < 6; i++) begin
            @(posedge pclk); #1;
            drx = 1'b1;
            chk(dtx_oe == 1'b0, "R11", "pre-fsync", int'(dtx_oe), 0);
            chk(rx_valid == 1'b0, "R12", "post-reset", int'(rx_valid), 0);
        end
        run_frame(32, 1, 0, 0, 1'b0, 1'b0, 1'b0, 16'hA5C3, 16'h3C96, "R2 start0");
        run_frame(64, 8, 9, 17, 1'b0, 1'b0, 1'b1, 16'h0F6B, 16'hFFD2, "R1 long fsync R4");
        run_frame(64, 60, 3, 20, 1'b1, 1'b0, 1'b0, 16'hB38E, 16'h71C5, "R1 R5");
        run_frame(128, 1, 5, 50, 1'b1, 1'b1, 1'b1, 16'h9A17, 16'hC0DE, "R6 wide");
        run_frame(32, 2, 40, 35, 1'b0, 1'b0, 1'b1, 16'h00FF, 16'h0055, "R11 beyond");
        run_frame(64, 1, 48, 40, 1'b0, 1'b1, 1'b0, 16'h12E4, 16'h00B9, "R6 narrow");
        run_frame(2100, 1, 3, 10, 1'b0, 1'b0, 1'b1, 16'h5A69, 16'h00A7, "R11 saturate");
        run_frame(32, 1, 0, 2, 1'b1, 1'b0, 1'b1, 16'h8001, 16'h4002, "R5 start0");
        done = 1'b1;
        report();
        $finish;
    end
endmodule